// File: doc/BRIEF.md
# Camera frame capture to SRAM

This block takes the pixel stream of a parallel image sensor and writes each frame into an external asynchronous SRAM of 2^18 words of 16 bits. The sensor's pixel clock, line-valid level, frame-sync level and 8-bit pixel byte all arrive without any timing relation to the system clock. Each reference input goes through its own two-flop synchronizer and a three-sample majority filter, so a level that lasts only one system clock has no effect. Pixels are taken on one pixel-clock edge, and a configuration input selects which edge.

Pixels are packed two to a word through the SRAM byte lanes. The first pixel of each pair goes to the low byte and the second to the high byte of the same word. The word address then advances. It counts up from zero, or down from the top word when mirrored storage is selected. Every SRAM write holds chip select, address, byte lanes and data steady for a programmable number of cycles before write enable falls.

The display side uses one of two capture modes. In single mode, an arm pulse captures the next full frame and capture then stops. In continuous mode, capture runs on every frame. A `frame_done` pulse marks the end of each captured frame. The write sequence takes SETUP_CYC+2 cycles. The sensor must therefore space its pixels further apart than that. It must also hold each pixel byte steady for at least eight system clocks after the sampling edge.

Top module: `cam_frame_capture`

## Requirements
- R1: While reset is active and directly after it, sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n and sram_lb_n are high and frame_done is low.
- R2: A pixel is written only on the selected pixel-clock edge (cfg_pclk_fall = 0: rising, 1: falling), while line-valid is high, frame-sync is low and a capture is active. No other edge or time writes.
- R3: A pulse on cam_pix_clk, cam_line_vld or cam_frame_sync that lasts a single system clock changes neither the writes nor the address sequence.
- R4: Counting pixels from 0 at frame start, an even pixel is written with sram_lb_n low, sram_ub_n high and the byte on sram_dq[7:0]. An odd pixel is written to the same address with sram_ub_n low, sram_lb_n high and the byte on sram_dq[15:8]. Exactly one lane is enabled while chip select is low.
- R5: A rising frame-sync edge resets the pair counter. It sets the word address to 0 when cfg_mirror is low at that edge, and the address then increments after every odd pixel.
- R6: When cfg_mirror is high at the frame-sync rise, the word address starts at 2^ADDR_W-1 and decrements after every odd pixel.
- R7: In single mode (cfg_continuous low), a one-cycle cap_arm pulse causes exactly the next frame to be captured. A frame with no pending arm is not written.
- R8: When cfg_continuous is high at a frame-sync rise, the frame that follows is captured, for every frame.
- R9: In every write, sram_ce_n is low and sram_addr, the byte lanes and sram_dq are stable for at least SETUP_CYC (default 2) cycles before sram_we_n falls. sram_we_n is low for exactly one cycle, and only while sram_ce_n is low. sram_oe_n stays high.
- R10: frame_done is a one-cycle pulse issued at the frame-sync rise that ends a captured frame, and only then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cam_pix_clk | input | 1 | Sensor pixel clock (asynchronous) |
| cam_line_vld | input | 1 | Sensor line-valid level, high during the active part of a line |
| cam_frame_sync | input | 1 | Sensor frame-sync, low during a frame, short high pulse at frame start |
| cam_pix | input | 8 | Sensor pixel byte |
| cfg_pclk_fall | input | 1 | 0: sample on rising pixel-clock edge, 1: on falling edge |
| cfg_mirror | input | 1 | Store the next frame with a decrementing address |
| cfg_continuous | input | 1 | 1: capture every frame, 0: single-frame mode |
| cap_arm | input | 1 | One-cycle pulse arming a single-frame capture |
| sram_addr | output | 18 | SRAM word address |
| sram_dq | output | 16 | SRAM write data |
| sram_ce_n | output | 1 | SRAM chip select, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low (held high) |
| sram_ub_n | output | 1 | SRAM high-byte enable, active low |
| sram_lb_n | output | 1 | SRAM low-byte enable, active low |
| frame_done | output | 1 | One-cycle pulse at the end of a captured frame |

## Verification
A pair counter that slips shows up on the very next write as the wrong byte lane, and one pixel later as an address that is off by one word. A lost capture-active flag shows up in the first pixel of a frame, either as a missing write or as an unexpected one. A filter that lets a one-clock glitch pass causes an extra write, or an address restart at the next pixel. A write sequencer that drops its setup shows up on that same write as address or chip select moving within the cycles just before write enable falls.

// File: rtl/cfc_pkg.sv
package cfc_pkg;
  localparam int REF_CNT   = 3;
  localparam int REF_PCLK  = 0;
  localparam int REF_LINE  = 1;
  localparam int REF_FRAME = 2;

  typedef enum logic [1:0] {
    WR_IDLE,
    WR_SETUP,
    WR_STROBE,
    WR_HOLD
  } wr_state_t;
endpackage

// File: rtl/cfc_sig_filter.sv
module cfc_sig_filter (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic       sync1_q, sync2_q;
  logic [2:0] hist_q;
  logic       maj_d;

  always_comb begin
    maj_d = (hist_q[0] & hist_q[1]) | (hist_q[0] & hist_q[2]) | (hist_q[1] & hist_q[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      hist_q  <= '0;
      dout    <= 1'b0;
    end else begin
      sync1_q <= din;
      sync2_q <= sync1_q;
      hist_q  <= {hist_q[1:0], sync2_q};
      dout    <= maj_d;
    end
  end
endmodule

// File: rtl/cfc_addr_gen.sv
module cfc_addr_gen #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              mirror,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              hi_lane
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              hi_q, hi_d;
  logic              down_q, down_d;

  always_comb begin
    addr_d = addr_q;
    hi_d   = hi_q;
    down_d = down_q;
    if (frame_start) begin
      addr_d = mirror ? {ADDR_W{1'b1}} : '0;
      hi_d   = 1'b0;
      down_d = mirror;
    end else if (step) begin
      hi_d = ~hi_q;
      if (hi_q) begin
        addr_d = down_q ? (addr_q - ADDR_W'(1)) : (addr_q + ADDR_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      hi_q   <= 1'b0;
      down_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      hi_q   <= hi_d;
      down_q <= down_d;
    end
  end

  assign addr    = addr_q;
  assign hi_lane = hi_q;
endmodule

// File: rtl/cfc_frame_ctl.sv
module cfc_frame_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_rise,
  input  logic cap_arm,
  input  logic cfg_continuous,
  output logic active,
  output logic frame_done
);
  logic active_q, active_d;
  logic armed_q, armed_d;
  logic done_q, done_d;

  always_comb begin
    active_d = active_q;
    armed_d  = armed_q | cap_arm;
    done_d   = 1'b0;
    if (frame_rise) begin
      done_d   = active_q;
      active_d = cfg_continuous | armed_q | cap_arm;
      armed_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      armed_q  <= armed_d;
      done_q   <= done_d;
    end
  end

  assign active     = active_q;
  assign frame_done = done_q;
endmodule

// File: rtl/cfc_wr_seq.sv
module cfc_wr_seq
  import cfc_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int PIX_W     = 8,
  parameter int SETUP_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                req_hi,
  input  logic [PIX_W-1:0]    req_pix,
  output logic                ready,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic [2*PIX_W-1:0]  sram_dq,
  output logic                sram_ce_n,
  output logic                sram_we_n,
  output logic                sram_ub_n,
  output logic                sram_lb_n
);
  localparam int CNT_W = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

  wr_state_t          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [2*PIX_W-1:0] dq_q, dq_d;
  logic               ce_n_q, ce_n_d, we_n_q, we_n_d;
  logic               ub_n_q, ub_n_d, lb_n_q, lb_n_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    dq_d   = dq_q;
    ce_n_d = ce_n_q;
    we_n_d = we_n_q;
    ub_n_d = ub_n_q;
    lb_n_d = lb_n_q;
    unique case (st_q)
      WR_IDLE: begin
        if (req) begin
          st_d   = WR_SETUP;
          cnt_d  = '0;
          addr_d = req_addr;
          dq_d   = {req_pix, req_pix};
          ce_n_d = 1'b0;
          ub_n_d = ~req_hi;
          lb_n_d = req_hi;
        end
      end
      WR_SETUP: begin
        if (cnt_q == CNT_W'(SETUP_CYC - 1)) begin
          st_d   = WR_STROBE;
          we_n_d = 1'b0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      WR_STROBE: begin
        st_d   = WR_HOLD;
        we_n_d = 1'b1;
      end
      default: begin
        st_d   = WR_IDLE;
        ce_n_d = 1'b1;
        ub_n_d = 1'b1;
        lb_n_d = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= WR_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      dq_q   <= '0;
      ce_n_q <= 1'b1;
      we_n_q <= 1'b1;
      ub_n_q <= 1'b1;
      lb_n_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      dq_q   <= dq_d;
      ce_n_q <= ce_n_d;
      we_n_q <= we_n_d;
      ub_n_q <= ub_n_d;
      lb_n_q <= lb_n_d;
    end
  end

  assign ready     = (st_q == WR_IDLE);
  assign sram_addr = addr_q;
  assign sram_dq   = dq_q;
  assign sram_ce_n = ce_n_q;
  assign sram_we_n = we_n_q;
  assign sram_ub_n = ub_n_q;
  assign sram_lb_n = lb_n_q;
endmodule

// File: rtl/cam_frame_capture.sv
module cam_frame_capture
  import cfc_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int PIX_W     = 8,
  parameter int SETUP_CYC = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cam_pix_clk,
  input  logic                cam_line_vld,
  input  logic                cam_frame_sync,
  input  logic [PIX_W-1:0]    cam_pix,
  input  logic                cfg_pclk_fall,
  input  logic                cfg_mirror,
  input  logic                cfg_continuous,
  input  logic                cap_arm,
  output logic [ADDR_W-1:0]   sram_addr,
  output logic [2*PIX_W-1:0]  sram_dq,
  output logic                sram_ce_n,
  output logic                sram_we_n,
  output logic                sram_oe_n,
  output logic                sram_ub_n,
  output logic                sram_lb_n,
  output logic                frame_done
);
  logic [1:0]         rst_pipe_q;
  logic               rst_n_int;
  logic [REF_CNT-1:0] ref_raw, ref_filt, ref_filt_q;
  logic [PIX_W-1:0]   pix_s1_q, pix_s2_q;
  logic               pclk_edge, frame_rise, capture_on, pix_evt, wr_ready;
  logic [ADDR_W-1:0]  cur_addr;
  logic               cur_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  assign ref_raw[REF_PCLK]  = cam_pix_clk;
  assign ref_raw[REF_LINE]  = cam_line_vld;
  assign ref_raw[REF_FRAME] = cam_frame_sync;

  for (genvar g = 0; g < REF_CNT; g++) begin : g_ref
    cfc_sig_filter u_filt (
      .clk  (clk),
      .rst_n(rst_n_int),
      .din  (ref_raw[g]),
      .dout (ref_filt[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ref_filt_q <= '0;
      pix_s1_q   <= '0;
      pix_s2_q   <= '0;
    end else begin
      ref_filt_q <= ref_filt;
      pix_s1_q   <= cam_pix;
      pix_s2_q   <= pix_s1_q;
    end
  end

  always_comb begin
    pclk_edge  = cfg_pclk_fall ? (ref_filt_q[REF_PCLK] & ~ref_filt[REF_PCLK])
                               : (ref_filt[REF_PCLK] & ~ref_filt_q[REF_PCLK]);
    frame_rise = ref_filt[REF_FRAME] & ~ref_filt_q[REF_FRAME];
    pix_evt    = pclk_edge & ref_filt[REF_LINE] & ~ref_filt[REF_FRAME] & capture_on & wr_ready;
  end

  cfc_frame_ctl u_ctl (
    .clk           (clk),
    .rst_n         (rst_n_int),
    .frame_rise    (frame_rise),
    .cap_arm       (cap_arm),
    .cfg_continuous(cfg_continuous),
    .active        (capture_on),
    .frame_done    (frame_done)
  );

  cfc_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .frame_start(frame_rise),
    .mirror     (cfg_mirror),
    .step       (pix_evt),
    .addr       (cur_addr),
    .hi_lane    (cur_hi)
  );

  cfc_wr_seq #(.ADDR_W(ADDR_W), .PIX_W(PIX_W), .SETUP_CYC(SETUP_CYC)) u_wr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req      (pix_evt),
    .req_addr (cur_addr),
    .req_hi   (cur_hi),
    .req_pix  (pix_s2_q),
    .ready    (wr_ready),
    .sram_addr(sram_addr),
    .sram_dq  (sram_dq),
    .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n),
    .sram_ub_n(sram_ub_n),
    .sram_lb_n(sram_lb_n)
  );

  assign sram_oe_n = 1'b1;
endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n,
  input logic              frame_done
);
  AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sram_we_n) |-> (!$past(sram_ce_n) && $stable(sram_addr) && $stable(sram_ub_n) && $stable(sram_lb_n))); // R9

  AST_WE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |=> sram_we_n); // R9

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> !sram_ce_n); // R9

  AST_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_ce_n |-> ($countones({~sram_ub_n, ~sram_lb_n}) == 1)); // R4

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R10
endmodule

bind cam_frame_capture cfc_checker #(.ADDR_W(ADDR_W)) u_cfc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sram_addr (sram_addr),
  .sram_ce_n (sram_ce_n),
  .sram_we_n (sram_we_n),
  .sram_ub_n (sram_ub_n),
  .sram_lb_n (sram_lb_n),
  .frame_done(frame_done)
);

// File: tb/cam_frame_capture_tb_top.sv
module cam_frame_capture_tb_top;
  localparam int AW = 18;

  typedef struct {
    logic [AW-1:0] addr;
    bit            hi;
    logic [7:0]    pix;
    string         rq;
  } wr_item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cam_pix_clk = 1'b0, cam_line_vld = 1'b0, cam_frame_sync = 1'b0;
  logic [7:0]    cam_pix = '0;
  logic          cfg_pclk_fall = 1'b0, cfg_mirror = 1'b0, cfg_continuous = 1'b0, cap_arm = 1'b0;
  logic [AW-1:0] sram_addr;
  logic [15:0]   sram_dq;
  logic          sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n, frame_done;

  int checks = 0, errors = 0, done_cnt = 0, exp_done = 0;
  wr_item_t      exp_q[$];
  logic [AW-1:0] e_addr = '0;
  bit            e_hi = 0, e_down = 0, prev_cap = 0;
  string         cur_rq = "R5";

  always #2 clk = ~clk;

  cam_frame_capture dut_i (
    .clk(clk), .rst_n(rst_n),
    .cam_pix_clk(cam_pix_clk), .cam_line_vld(cam_line_vld),
    .cam_frame_sync(cam_frame_sync), .cam_pix(cam_pix),
    .cfg_pclk_fall(cfg_pclk_fall), .cfg_mirror(cfg_mirror),
    .cfg_continuous(cfg_continuous), .cap_arm(cap_arm),
    .sram_addr(sram_addr), .sram_dq(sram_dq), .sram_ce_n(sram_ce_n),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n),
    .sram_lb_n(sram_lb_n), .frame_done(frame_done)
  );

  task automatic chk(input bit ok, input string rq, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // monitor: compares every write strobe against the scoreboard
  logic [AW-1:0] prev_addr;
  logic          prev_ce_n = 1'b1, prev_we_n = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) done_cnt++;
      if (!sram_we_n && prev_we_n) begin
        chk(prev_ce_n == 1'b0 && prev_addr == sram_addr, "R9", "setup before write strobe",
            {prev_ce_n, prev_addr}, {1'b0, sram_addr});
        chk(sram_oe_n == 1'b1, "R9", "oe_n during write", sram_oe_n, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected write addr", sram_addr, 0);
        end else begin
          wr_item_t it;
          it = exp_q.pop_front();
          chk(sram_addr == it.addr, it.rq, "write address", sram_addr, it.addr);
          chk({sram_ub_n, sram_lb_n} == (it.hi ? 2'b01 : 2'b10), "R4", "byte lanes",
              {sram_ub_n, sram_lb_n}, it.hi ? 2'b01 : 2'b10);
          chk((it.hi ? sram_dq[15:8] : sram_dq[7:0]) == it.pix, "R4", "lane data",
              it.hi ? sram_dq[15:8] : sram_dq[7:0], it.pix);
        end
      end
      prev_addr = sram_addr;
      prev_ce_n = sram_ce_n;
      prev_we_n = sram_we_n;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: one pixel per call, pushes the expected write when capturing
  task automatic drive_px(input logic [7:0] d, input bit cap, input bit pclk_glitch);
    cam_pix = d;
    wait_clk(3);
    if (pclk_glitch) begin
      cam_pix_clk = ~cfg_pclk_fall;
      wait_clk(1);
      cam_pix_clk = cfg_pclk_fall;
      wait_clk(4);
    end else wait_clk(5);
    cam_pix_clk = ~cfg_pclk_fall;
    if (cap) begin
      wr_item_t it;
      it.addr = e_addr; it.hi = e_hi; it.pix = d; it.rq = cur_rq;
      exp_q.push_back(it);
      if (e_hi) e_addr = e_down ? e_addr - 1'b1 : e_addr + 1'b1;
      e_hi = ~e_hi;
    end
    wait_clk(8);
    cam_pix_clk = cfg_pclk_fall;
  endtask

  task automatic frame_sync(input bit next_cap);
    cam_frame_sync = 1'b1;
    wait_clk(6);
    cam_frame_sync = 1'b0;
    wait_clk(8);
    if (prev_cap) exp_done++;
    chk(done_cnt == exp_done, "R10", "frame_done count", done_cnt, exp_done);
    e_addr = cfg_mirror ? '1 : '0;
    e_down = cfg_mirror;
    e_hi = 0;
    prev_cap = next_cap;
  endtask

  task automatic frame(input bit cap, input int lines, input int ppl, input logic [7:0] seed, input bit glitch);
    frame_sync(cap);
    for (int l = 0; l < lines; l++) begin
      cam_line_vld = 1'b1;
      wait_clk(6);
      for (int p = 0; p < ppl; p++) drive_px(seed + 8'(l * 16 + p), cap, glitch && p == 1);
      wait_clk(6);
      cam_line_vld = 1'b0;
      wait_clk(10);
      if (glitch) begin
        // R3: one-clock frame-sync and line-valid pulses between lines
        cam_frame_sync = 1'b1; wait_clk(1); cam_frame_sync = 1'b0; wait_clk(10);
        cam_pix = 8'hEE; wait_clk(6);
        cam_pix_clk = ~cfg_pclk_fall; wait_clk(2);
        cam_line_vld = 1'b1; wait_clk(1); cam_line_vld = 1'b0;
        wait_clk(6); cam_pix_clk = cfg_pclk_fall; wait_clk(12);
      end
    end
    wait_clk(10);
    chk(exp_q.size() == 0, cur_rq, "writes outstanding at frame end", exp_q.size(), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    wait_clk(5);
    // R1: outputs while in reset
    chk({sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n} == 5'h1f, "R1", "strobes in reset",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n}, 5'h1f);
    rst_n = 1'b1;
    wait_clk(6);
    chk({sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n} == 5'h1f, "R1", "strobes after reset",
        {sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n}, 5'h1f);
    chk(frame_done == 1'b0, "R1", "frame_done after reset", frame_done, 0);

    // R7: single mode without an arm writes nothing
    cur_rq = "R7";
    frame(0, 1, 4, 8'h10, 0);
    // R7 with R4/R5: arm, then capture one frame counting up
    @(negedge clk) cap_arm = 1'b1;
    @(negedge clk) cap_arm = 1'b0;
    cur_rq = "R5";
    frame(1, 2, 5, 8'h30, 0);
    // R7: the following frame is not captured (its start ends the captured one, R10)
    cur_rq = "R7";
    frame(0, 1, 4, 8'h50, 0);

    // R8: continuous mode, two frames
    cfg_continuous = 1'b1;
    cur_rq = "R8";
    frame(1, 2, 4, 8'h60, 0);
    // R6: mirrored frame counting down from the top word
    cfg_mirror = 1'b1;
    cur_rq = "R6";
    frame(1, 2, 3, 8'h80, 0);
    cfg_mirror = 1'b0;

    // R2: falling-edge sampling; idle level changes while line-valid is low
    cfg_pclk_fall = 1'b1;
    cam_pix_clk = 1'b1;
    wait_clk(12);
    cur_rq = "R2";
    frame(1, 2, 4, 8'hA0, 0);

    // R3: one-clock glitches on pixel clock, frame sync and line valid
    cur_rq = "R3";
    frame(1, 2, 4, 8'hC0, 1);

    // R10: closing frame sync ends the last captured frame
    cfg_continuous = 1'b0;
    cur_rq = "R10";
    frame(0, 1, 2, 8'hD0, 0);
    frame_sync(0);
    chk(exp_q.size() == 0, "R2", "scoreboard empty", exp_q.size(), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule